// File: doc/BRIEF.md
# Two-Stage Lockable Bus Watchdog

This block is a watchdog timer that sits on an APB bus. It has a 32-bit down-counter that reloads from a software-set value. The counter moves only on clock cycles where the counter-enable input `tick_en` is high, so it runs as a synchronous enable on the bus clock.

The timeout happens in two stages:
- The first time the count reaches zero, the block raises an interrupt and reloads on the next enabled cycle.
- If that interrupt is still uncleared when zero comes round again, and reset generation is enabled, the block drives a sticky system-reset output and stops counting.

A write-lock register protects all other registers: writes are accepted only while the lock holds the unlock key.

The counter is driven by four named states:
- **IDLE**: the count is frozen. The block leaves IDLE for ARM when the interrupt enable is set.
- **ARM**: the block waits for the first enabled cycle, loads the count from the reload value and goes to COUNT. It goes back to IDLE if the interrupt enable is cleared.
- **COUNT**: the count decrements. Clearing the interrupt enable returns the block to IDLE. Reaching zero with an interrupt pending and reset enabled goes to HALT.
- **HALT**: the block stays here until the block is reset.

Register map (byte offsets):

| Offset | Register | Access |
|---|---|---|
| 0x00 | reload value | read/write |
| 0x04 | live count | read only |
| 0x08 | control: bit0 interrupt enable, bit1 reset enable | read/write |
| 0x0C | interrupt clear | write only |
| 0x10 | raw interrupt status, bit0 | read only |
| 0x14 | masked interrupt status, bit0 | read only |
| 0x40 | lock | read/write |

Top module: `wdt_apb`

## Requirements
- R1: The count changes on a `tick_en` cycle only while in COUNT (or on the loading cycle of ARM). With `tick_en` low and no bus write, it holds. In COUNT each enabled cycle lowers it by one.
- R2: After reset:
  - the count reads 0xFFFFFFFF
  - control reads 0 and the lock reads 0 (unlocked)
  - raw status reads 0
  - `irq_o` and `sys_rst_o` are low
- R3: Setting the interrupt enable (control bit0) moves IDLE to ARM. The first `tick_en` cycle in ARM loads the count from the reload register.
- R4: A decrement from 1 to 0 sets the raw interrupt (status bit0 = 1). The next enabled cycle at zero reloads the count from the reload register.
- R5: A decrement reaching 0 while the raw interrupt is already set behaves according to the reset enable (control bit1):
  - If it is 1, `sys_rst_o` rises and stays high, the count stops at 0, and the state is HALT.
  - If it is 0, counting continues and no reset is produced.
- R6: A write of any data to offset 0x0C clears the raw interrupt and, in COUNT, reloads the count in the same cycle.
- R7: A write to the reload register in COUNT loads the new value into the count at the same clock edge. It leaves the raw interrupt unchanged.
- R8: Clearing the interrupt enable freezes the count at its current value. Setting it again restarts from the reload value on the first enabled cycle.
- R9: Writing 0x1ACCE551 to the lock register unlocks it. Any other value locks it. While locked, writes to every other offset are ignored.
- R10: The lock register reads 1 when locked and 0 when unlocked.
- R11: `irq_o` and the masked status equal raw status AND the interrupt enable.
- R12: `pready` is always high (zero wait states). Writes to unmapped offsets are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus and counter clock |
| rst_n | input | 1 | active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| tick_en | input | 1 | counter clock enable |
| irq_o | output | 1 | masked interrupt |
| sys_rst_o | output | 1 | system reset request |

## Verification
Register writes take effect at the clock edge that ends the APB access phase. Reads are combinational during the access phase, so the bench samples `prdata` at the falling edge inside that phase.

A counter update from `tick_en` appears one edge after the enabled cycle. The interrupt and reset pins change at the same edge as the count move that reaches zero.

The bench drives ticks only in explicit bursts that do not overlap bus cycles. This means each expected count is the reload value minus the number of enabled edges since the last load. Every check is made at a falling edge after the burst or transfer has finished.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    localparam logic [7:0] OFS_LOAD  = 8'h00;
    localparam logic [7:0] OFS_COUNT = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h08;
    localparam logic [7:0] OFS_ICLR  = 8'h0C;
    localparam logic [7:0] OFS_RAW   = 8'h10;
    localparam logic [7:0] OFS_MASK  = 8'h14;
    localparam logic [7:0] OFS_LOCK  = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2,
        ST_HALT  = 2'd3
    } wdt_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              raw_irq,
    output logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] load_q,
    output logic              inten_q,
    output logic              resen_q,
    output logic              load_wr,
    output logic              clr_wr,
    output logic              wr_any
);
    logic open_q;
    logic wr_ok;
    logic [7:0] ofs;

    assign ofs     = 8'(paddr);
    assign wr_any  = psel && penable && pwrite;
    assign wr_ok   = wr_any && open_q;
    assign load_wr = wr_ok && (ofs == OFS_LOAD);
    assign clr_wr  = wr_ok && (ofs == OFS_ICLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q  <= 1'b1;
            load_q  <= '1;
            inten_q <= 1'b0;
            resen_q <= 1'b0;
        end else begin
            if (wr_any && ofs == OFS_LOCK)
                open_q <= (pwdata[31:0] == UNLOCK_KEY);
            if (load_wr)
                load_q <= pwdata;
            if (wr_ok && ofs == OFS_CTRL) begin
                inten_q <= pwdata[0];
                resen_q <= pwdata[1];
            end
        end
    end

    always_comb begin
        prdata = '0;
        unique case (ofs)
            OFS_LOAD:  prdata = load_q;
            OFS_COUNT: prdata = cnt;
            OFS_CTRL:  prdata[1:0] = {resen_q, inten_q};
            OFS_RAW:   prdata[0] = raw_irq;
            OFS_MASK:  prdata[0] = raw_irq && inten_q;
            OFS_LOCK:  prdata[0] = !open_q;
            default:   prdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             inten,
    input  logic             resen,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] load_new,
    input  logic             load_wr,
    input  logic             clr_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             raw_q,
    output logic             rst_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             raw_d, rst_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '1;
            raw_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            raw_q   <= raw_d;
            rst_q   <= rst_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        raw_d   = raw_q;
        rst_d   = rst_q;
        if (clr_wr && state_q != ST_HALT)
            raw_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (inten)
                    state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!inten)
                    state_d = ST_IDLE;
                else if (tick_en) begin
                    cnt_d   = load_val;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!inten)
                    state_d = ST_IDLE;
                else if (load_wr)
                    cnt_d = load_new;
                else if (clr_wr)
                    cnt_d = load_val;
                else if (tick_en) begin
                    if (cnt_q == '0)
                        cnt_d = load_val;
                    else begin
                        cnt_d = cnt_q - CNT_ONE;
                        if (cnt_q == CNT_ONE) begin
                            if (raw_q && resen) begin
                                rst_d   = 1'b1;
                                state_d = ST_HALT;
                            end else
                                raw_d = 1'b1;
                        end
                    end
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wdt_apb.sv
module wdt_apb #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              tick_en,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic [DATA_W-1:0] cnt_w, load_w;
    logic raw_w, inten_w, resen_w, load_wr_w, clr_wr_w, wr_any_w;

    assign pready = 1'b1;

    wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .cnt(cnt_w), .raw_irq(raw_w), .prdata(prdata),
        .load_q(load_w), .inten_q(inten_w), .resen_q(resen_w),
        .load_wr(load_wr_w), .clr_wr(clr_wr_w), .wr_any(wr_any_w)
    );

    wdt_core #(.CNT_W(DATA_W)) core_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .inten(inten_w), .resen(resen_w), .load_val(load_w),
        .load_new(pwdata), .load_wr(load_wr_w), .clr_wr(clr_wr_w),
        .cnt_q(cnt_w), .raw_q(raw_w), .rst_q(sys_rst_o)
    );

    assign irq_o = raw_w && inten_w;
endmodule

// File: rtl/wdt_apb_chk.sv
module wdt_apb_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_any,
    input logic              inten,
    input logic              raw,
    input logic [DATA_W-1:0] cnt,
    input logic              irq_o,
    input logic              sys_rst_o
);
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_any) |=> $stable(cnt)); // R1
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> sys_rst_o); // R5
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> $stable(cnt)); // R5
    AST_RST_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(raw) && cnt == '0)); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !inten |-> !irq_o); // R11
endmodule

bind wdt_apb wdt_apb_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_any(wr_any_w),
    .inten(inten_w), .raw(raw_w), .cnt(cnt_w),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/wdt_apb_tb_top.sv
module wdt_apb_tb_top;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_P = 2'd3;
    localparam logic [7:0] A_LOAD = 8'h00, A_CNT = 8'h04, A_CTRL = 8'h08,
                           A_ICLR = 8'h0C, A_RAW = 8'h10, A_MASK = 8'h14,
                           A_LOCK = 8'h40, A_GAP = 8'h30;
    localparam int NV = 46;
    // {op, addr, data (write data or tick count), expected, requirement number}
    localparam logic [81:0] VEC [NV] = '{
        {OP_W, A_LOAD, 32'd5, 32'd0, 8'd9},            // R9 writes open
        {OP_T, A_CNT, 32'd3, 32'd0, 8'd1},
        {OP_R, A_CNT, 32'd0, 32'hFFFF_FFFF, 8'd1},     // R1 no count while idle
        {OP_W, A_CTRL, 32'd3, 32'd0, 8'd3},
        {OP_R, A_CTRL, 32'd0, 32'd3, 8'd9},            // R9 unlocked write lands
        {OP_T, A_CNT, 32'd1, 32'd0, 8'd3},
        {OP_R, A_CNT, 32'd0, 32'd5, 8'd3},             // R3 first tick loads
        {OP_T, A_CNT, 32'd2, 32'd0, 8'd1},
        {OP_R, A_CNT, 32'd0, 32'd3, 8'd1},             // R1 decrement
        {OP_T, A_CNT, 32'd3, 32'd0, 8'd4},
        {OP_R, A_CNT, 32'd0, 32'd0, 8'd4},             // R4 reaches zero
        {OP_R, A_RAW, 32'd0, 32'd1, 8'd4},             // R4 raw set
        {OP_P, A_CNT, 32'd0, 32'd1, 8'd11},            // R11 irq pin
        {OP_T, A_CNT, 32'd1, 32'd0, 8'd4},
        {OP_R, A_CNT, 32'd0, 32'd5, 8'd4},             // R4 reload after zero
        {OP_T, A_CNT, 32'd2, 32'd0, 8'd1},
        {OP_R, A_CNT, 32'd0, 32'd3, 8'd1},
        {OP_W, A_ICLR, 32'hDEAD, 32'd0, 8'd6},
        {OP_R, A_CNT, 32'd0, 32'd5, 8'd6},             // R6 reload
        {OP_R, A_RAW, 32'd0, 32'd0, 8'd6},             // R6 clear
        {OP_T, A_CNT, 32'd5, 32'd0, 8'd4},
        {OP_R, A_RAW, 32'd0, 32'd1, 8'd4},
        {OP_W, A_LOAD, 32'd9, 32'd0, 8'd7},
        {OP_R, A_CNT, 32'd0, 32'd9, 8'd7},             // R7 immediate load
        {OP_R, A_RAW, 32'd0, 32'd1, 8'd7},             // R7 irq kept
        {OP_T, A_CNT, 32'd2, 32'd0, 8'd1},
        {OP_R, A_CNT, 32'd0, 32'd7, 8'd1},
        {OP_W, A_CTRL, 32'd2, 32'd0, 8'd8},
        {OP_R, A_MASK, 32'd0, 32'd0, 8'd11},           // R11 masked status
        {OP_P, A_CNT, 32'd0, 32'd0, 8'd11},            // R11 irq pin masked
        {OP_T, A_CNT, 32'd3, 32'd0, 8'd8},
        {OP_R, A_CNT, 32'd0, 32'd7, 8'd8},             // R8 frozen
        {OP_W, A_CTRL, 32'd3, 32'd0, 8'd8},
        {OP_T, A_CNT, 32'd1, 32'd0, 8'd8},
        {OP_R, A_CNT, 32'd0, 32'd9, 8'd8},             // R8 restart from load
        {OP_W, A_LOCK, 32'd0, 32'd0, 8'd10},
        {OP_R, A_LOCK, 32'd0, 32'd1, 8'd10},           // R10 locked reads 1
        {OP_W, A_LOAD, 32'd2, 32'd0, 8'd9},
        {OP_R, A_LOAD, 32'd0, 32'd9, 8'd9},            // R9 blocked
        {OP_W, A_ICLR, 32'd0, 32'd0, 8'd9},
        {OP_R, A_RAW, 32'd0, 32'd1, 8'd9},             // R9 clear blocked
        {OP_W, A_LOCK, 32'h1ACC_E551, 32'd0, 8'd10},
        {OP_R, A_LOCK, 32'd0, 32'd0, 8'd10},           // R10 unlocked reads 0
        {OP_T, A_CNT, 32'd9, 32'd0, 8'd5},
        {OP_P, A_CNT, 32'd0, 32'd3, 8'd5},             // R5 reset asserted
        {OP_R, A_CNT, 32'd0, 32'd0, 8'd5}              // R5 stopped at zero
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick_en = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, irq_o, sys_rst_o;
    int n_chk = 0, n_err = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    wdt_apb dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .tick_en(tick_en), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        psel = 1'b1; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        r = prdata;
        check(12, {31'd0, pready}, 32'd1);               // R12 zero wait
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        check(2, {30'd0, sys_rst_o, irq_o}, 32'd0);      // R2 pins
        bus(1'b0, A_CNT, 0, rd);  check(2, rd, 32'hFFFF_FFFF);
        bus(1'b0, A_CTRL, 0, rd); check(2, rd, 32'd0);
        bus(1'b0, A_LOCK, 0, rd); check(2, rd, 32'd0);
        bus(1'b0, A_RAW, 0, rd);  check(2, rd, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [81:0] v;
            v = VEC[i];
            unique case (v[81:80])
                OP_W: bus(1'b1, v[79:72], v[71:40], rd);
                OP_R: begin bus(1'b0, v[79:72], 0, rd); check(int'(v[7:0]), rd, v[39:8]); end
                OP_T: ticks(int'(v[71:40]));
                OP_P: begin @(negedge clk); check(int'(v[7:0]), {30'd0, sys_rst_o, irq_o}, v[39:8]); end
            endcase
        end
        ticks(3);
        bus(1'b0, A_CNT, 0, rd); check(5, rd, 32'd0);      // R5 halted stays
        check(5, {31'd0, sys_rst_o}, 32'd1);

        // R5 without reset enable, counting continues
        do_reset();
        check(2, {30'd0, sys_rst_o, irq_o}, 32'd0);
        bus(1'b1, A_LOAD, 32'd2, rd);
        bus(1'b1, A_CTRL, 32'd1, rd);
        ticks(3);
        check(4, {31'd0, irq_o}, 32'd1);
        ticks(3);
        check(5, {30'd0, sys_rst_o, irq_o}, 32'd1);
        ticks(1);
        bus(1'b0, A_CNT, 0, rd); check(5, rd, 32'd2);

        // R12 unmapped offsets
        bus(1'b1, A_GAP, 32'hFFFF_FFFF, rd);
        bus(1'b0, A_GAP, 0, rd);    check(12, rd, 32'd0);
        bus(1'b0, A_LOAD, 0, rd);   check(12, rd, 32'd2);
        bus(1'b0, A_CTRL, 0, rd);   check(12, rd, 32'd1);
        bus(1'b0, A_CNT, 0, rd);    check(12, rd, 32'd2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule